// File: doc/BRIEF.md
# Return-Edge Label Guard

This block sits next to an instruction decoder. It enforces backward-edge control-flow integrity with a label store that only the hardware can reach. For each retired instruction the decoder hands over one operation code and a 16-bit label. Five operations matter:

- **Enter** marks a function's label live.
- **Drop** retires that label just before the function returns.
- **Return** arms a one-shot demand that the next retired instruction be a check.
- **Check** sits right after a call site and confirms that the caller's label is still live.
- **Call** and every other code pass through with no effect on state.

The block reports a violation when:

- a check names a label that is not live;
- a return is not immediately followed by a check;
- the store is full when a new label must go in;
- a drop names a label that is not live.

A violation raises a halt request and a code, and both hold until reset.

Operations arrive on a valid/ready stream. `in_ready` is high from reset until the first violation. While halted, the block applies back-pressure for good: nothing more is accepted and the state is frozen. A cycle with `in_valid` low is not a retired instruction and is ignored.

Top module: `cfi_ret_guard`

## Requirements
- R1: After synchronous reset, `halt` is 0, `viol_code` is 0, `in_ready` is 1, no label is live and no check is pending.
- R2: Operation codes on `in_op` are: 0 none, 1 enter, 2 check, 3 drop, 4 call, 5 return; 6 and 7 act like 0. An accepted enter makes its label live. Entering a label that is already live uses no extra slot and raises no violation.
- R3: An accepted check of a live label causes no violation. A check of a label that is not live gives code 1.
- R4: An accepted drop of a live label makes it not live, so a later check of it gives code 1.
- R5: An accepted drop of a label that is not live gives code 4.
- R6: After an accepted return, the next accepted operation must be a check, otherwise code 2. A check clears this demand. Cycles with `in_valid` low do not consume it.
- R7: The store holds 32 distinct labels. A 33rd distinct enter gives code 3. Entering an already-live label while full is legal.
- R8: `halt` and `viol_code` are registered. They change on the clock edge that accepts the offending operation, hold until reset, and `in_ready` is 0 while `halt` is 1, so later operations change nothing.
- R9: When a pending check demand is broken by an operation that is itself faulty, the reported code is 2.
- R10: `viol_code` is 0 while `halt` is 0 and one of 1..4 while `halt` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Retired operation present |
| in_ready | output | 1 | Operation accepted when high together with in_valid |
| in_op | input | 3 | Operation code (see R2) |
| in_label | input | 16 | Label carried by the operation |
| halt | output | 1 | Sticky halt request |
| viol_code | output | 3 | First violation code, 0 when none |

## Verification
Two judgments can fall in the same cycle: the pending-check demand left by a return, and the faults of the operation that follows it (an inactive label on a drop, or a full store on an enter). The bench provokes this by sending a return and then a drop of a label that was never entered. It expects code 2, not 4. It also confirms that an idle cycle between a return and its check does not trip the demand.

// File: rtl/cfi_guard_pkg.sv
package cfi_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ENTER = 3'd1,
    OP_CHECK = 3'd2,
    OP_DROP  = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } cfi_op_e;

  typedef enum logic [2:0] {
    VC_NONE     = 3'd0,
    VC_INACTIVE = 3'd1,
    VC_NOCHECK  = 3'd2,
    VC_FULL     = 3'd3,
    VC_STALE    = 3'd4
  } cfi_viol_e;
endpackage

// File: rtl/cfi_label_store.sv
module cfi_label_store #(
  parameter int LABEL_W = 16,
  parameter int DEPTH   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LABEL_W-1:0] key,
  input  logic               ins_en,
  input  logic               rem_en,
  output logic               hit,
  output logic               full
);
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]   live_q;
  logic [LABEL_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0]   hit_vec;
  logic [IDXW-1:0]    free_idx;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = live_q[g] && (tag_q[g] == key);
    end
  endgenerate

  assign hit  = |hit_vec;
  assign full = &live_q;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live_q[i]) free_idx = IDXW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (ins_en && !hit && !full) begin
      live_q[free_idx] <= 1'b1;
    end else if (rem_en) begin
      live_q <= live_q & ~hit_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && !hit && !full) tag_q[free_idx] <= key;
  end

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_vec) <= 1); // R2

  AST_STORE_GROWS: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !hit && !full) |=> $countones(live_q) == $past($countones(live_q)) + 1); // R2

  AST_DROP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (rem_en && hit) |=> $countones(live_q) == $past($countones(live_q)) - 1); // R4
endmodule

// File: rtl/cfi_flow_judge.sv
module cfi_flow_judge
  import cfi_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fire,
  input  cfi_op_e   op,
  input  logic      hit,
  input  logic      full,
  output cfi_viol_e code,
  output logic      ins_en,
  output logic      rem_en
);
  logic expect_q;
  logic miss, inact, ovf, stale;

  assign miss  = fire && expect_q && (op != OP_CHECK);
  assign inact = fire && (op == OP_CHECK) && !hit;
  assign ovf   = fire && (op == OP_ENTER) && !hit && full;
  assign stale = fire && (op == OP_DROP) && !hit;

  always_comb begin
    if (miss)       code = VC_NOCHECK;
    else if (inact) code = VC_INACTIVE;
    else if (ovf)   code = VC_FULL;
    else if (stale) code = VC_STALE;
    else            code = VC_NONE;
  end

  assign ins_en = fire && (code == VC_NONE) && (op == OP_ENTER);
  assign rem_en = fire && (code == VC_NONE) && (op == OP_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_q <= 1'b0;
    end else if (fire && code == VC_NONE) begin
      expect_q <= (op == OP_RET);
    end
  end

  AST_ARM_AFTER_RET: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_RET && code == VC_NONE) |=> expect_q); // R6

  AST_IDLE_KEEPS_ARM: assert property (@(posedge clk) disable iff (rst)
    (!fire) |=> $stable(expect_q)); // R6
endmodule

// File: rtl/cfi_ret_guard.sv
module cfi_ret_guard
  import cfi_guard_pkg::*;
#(
  parameter int LABEL_W = 16,
  parameter int DEPTH   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_op,
  input  logic [LABEL_W-1:0] in_label,
  output logic               halt,
  output logic [2:0]         viol_code
);
  logic      halt_q;
  cfi_viol_e code_q;
  cfi_viol_e cur_code;
  logic      fire, hit, full, ins_en, rem_en;

  assign in_ready = !halt_q;
  assign fire     = in_valid && in_ready;

  cfi_label_store #(.LABEL_W(LABEL_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .key(in_label),
    .ins_en(ins_en), .rem_en(rem_en), .hit(hit), .full(full)
  );

  cfi_flow_judge judge_i (
    .clk(clk), .rst(rst), .fire(fire), .op(cfi_op_e'(in_op)),
    .hit(hit), .full(full), .code(cur_code),
    .ins_en(ins_en), .rem_en(rem_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      code_q <= VC_NONE;
    end else if (cur_code != VC_NONE) begin
      halt_q <= 1'b1;
      code_q <= cur_code;
    end
  end

  assign halt      = halt_q;
  assign viol_code = code_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt); // R8

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(viol_code)); // R8

  AST_CODE_MATCHES_HALT: assert property (@(posedge clk) disable iff (rst)
    halt == (viol_code != 3'd0)); // R10

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    viol_code <= 3'd4); // R10
endmodule

// File: tb/cfi_ret_guard_tb.sv
`timescale 1ns/1ps
module cfi_ret_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [15:0] in_label;
  logic        halt;
  logic [2:0]  viol_code;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cfi_ret_guard dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_label(in_label), .halt(halt), .viol_code(viol_code)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  op;
    logic [15:0] lab;
    logic        eh;
    logic [2:0]  ec;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 16'h0025, 1'b0, 3'd0},
    '{1'b1, 3'd1, 16'h0099, 1'b0, 3'd0},
    '{1'b1, 3'd1, 16'h0099, 1'b0, 3'd0},
    '{1'b1, 3'd4, 16'h0000, 1'b0, 3'd0},
    '{1'b1, 3'd3, 16'h0099, 1'b0, 3'd0},
    '{1'b1, 3'd5, 16'h0000, 1'b0, 3'd0},
    '{1'b0, 3'd0, 16'h0000, 1'b0, 3'd0},
    '{1'b1, 3'd2, 16'h0025, 1'b0, 3'd0},
    '{1'b1, 3'd0, 16'h0000, 1'b0, 3'd0},
    '{1'b1, 3'd2, 16'h0025, 1'b0, 3'd0},
    '{1'b1, 3'd5, 16'h0000, 1'b0, 3'd0},
    '{1'b1, 3'd2, 16'h0099, 1'b1, 3'd1},
    '{1'b1, 3'd1, 16'h0444, 1'b1, 3'd1}
  };

  task automatic chk(input string req, input logic eh, input logic [2:0] ec);
    checks++;
    if (halt !== eh || viol_code !== ec) begin
      errors++;
      $display("FAIL %s: halt=%0b code=%0d expected halt=%0b code=%0d",
               req, halt, viol_code, eh, ec);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [15:0] lab);
    in_valid = v;
    in_op    = op;
    in_label = lab;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    in_op = 3'd0;
    in_label = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1", 1'b0, 3'd0);
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: in_ready=%0b expected 1", in_ready);
    end

    // Table: R2 R3 R4 R6 R8 walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].v, VECS[i].op, VECS[i].lab);
      chk("R2/R3/R4/R6 table", VECS[i].eh, VECS[i].ec);
    end
    // R8 ignored while halted
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R8: in_ready=%0b expected 0", in_ready);
    end

    // R1 reset clears store: 0x0025 no longer live
    do_reset();
    chk("R1", 1'b0, 3'd0);
    step(1'b1, 3'd2, 16'h0025);
    chk("R1", 1'b1, 3'd1);

    // R6 missing check after return
    do_reset();
    step(1'b1, 3'd1, 16'h0010);
    step(1'b1, 3'd5, 16'h0000);
    chk("R6", 1'b0, 3'd0);
    step(1'b1, 3'd4, 16'h0000);
    chk("R6", 1'b1, 3'd2);

    // R5 drop of inactive label
    do_reset();
    step(1'b1, 3'd3, 16'h0777);
    chk("R5", 1'b1, 3'd4);

    // R9 return then faulty drop: code 2 wins over 4
    do_reset();
    step(1'b1, 3'd5, 16'h0000);
    step(1'b1, 3'd3, 16'h0777);
    chk("R9", 1'b1, 3'd2);

    // R7 fill store, re-enter, then overflow
    do_reset();
    for (int k = 0; k < 32; k++) step(1'b1, 3'd1, 16'h0100 + 16'(k));
    chk("R7", 1'b0, 3'd0);
    step(1'b1, 3'd1, 16'h0100);
    chk("R7 re-enter when full", 1'b0, 3'd0);
    step(1'b1, 3'd2, 16'h011F);
    chk("R7 last slot live", 1'b0, 3'd0);
    step(1'b1, 3'd1, 16'h0200);
    chk("R7 overflow", 1'b1, 3'd3);
    // R8 code held despite further traffic
    step(1'b1, 3'd3, 16'h0999);
    step(1'b1, 3'd5, 16'h0000);
    step(1'b1, 3'd0, 16'h0000);
    chk("R8 hold", 1'b1, 3'd3);

    // R2 reserved codes act like none; R4 drop then re-enter works
    do_reset();
    step(1'b1, 3'd1, 16'h0042);
    step(1'b1, 3'd5, 16'h0000);
    step(1'b1, 3'd6, 16'h0000);
    chk("R2 reserved op breaks check demand", 1'b1, 3'd2);

    do_reset();
    step(1'b1, 3'd1, 16'h0042);
    step(1'b1, 3'd3, 16'h0042);
    step(1'b1, 3'd1, 16'h0042);
    step(1'b1, 3'd2, 16'h0042);
    chk("R4 re-enter after drop", 1'b0, 3'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule